// File: doc/BRIEF.md
# CRU Single-Bit Instruction Executor

This unit is the processor-side engine behind the three single-bit communication-register-unit operations: drive a bit high, drive a bit low, and read a bit. It receives an already-decoded 16-bit instruction word and the current contents of the CRU base register. From these it forms a bit address, then runs one serial-bus transaction on the CRU lines. A bit read returns the sampled line value as the equal-status flag.

The bit address is the base register plus twice the signed 8-bit displacement carried in the instruction's low byte. The sum wraps modulo 2^16. The three most-significant lines and the least-significant line are never presented, so the bus carries a 12-bit bit index taken from sum bits 12..1. The base register holds the address as it appears on the bus. Moving the base up by 2 therefore has the same effect as raising the displacement by 1.

An instruction is accepted only when the unit is idle. Each accepted instruction occupies three busy cycles: address setup, transfer, and finish.

Top module: `cru_bit_exec`

## Requirements
- R1: While reset is held and in the first cycle after it, `idle`=1, `done`=0, `cru_wstb`=0, `cru_dout`=0, `eq_flag`=0 and `cru_idx`=0.
- R2: The bus index equals bits 12..1 of (`base_reg` + 2·sign-extended `instr_word[7:0]`) mod 2^16. Bits 15..13 and bit 0 of that sum have no effect on the index.
- R3: A base of 0x1F00 with displacement 1 yields the same index (0xF81) as a base of 0x1F02 with displacement 0.
- R4: A negative displacement (`instr_word[7]`=1) selects a lower bit index, and the sum wraps below zero modulo 2^16.
- R5: High byte 0x1D (set) drives `cru_dout`=1 and the index in the first busy cycle. `cru_wstb` is high for exactly the second busy cycle, and index and data are held unchanged while it is high.
- R6: High byte 0x1E (clear) behaves as R5 but drives `cru_dout`=0.
- R7: High byte 0x1F (test) never raises `cru_wstb` and leaves `cru_dout` unchanged. It samples `cru_din` during the second busy cycle. `eq_flag` shows that value from the third busy cycle until the next test completes.
- R8: `idle` is low for exactly three cycles after an accepted instruction. `done` is high for exactly the third of them.
- R9: `instr_valid` is ignored while `idle` is low. The index, data and sequence of the running instruction are unaffected, and no second instruction starts.
- R10: A valid instruction whose high byte is not 0x1D, 0x1E or 0x1F is ignored. `idle` stays 1, `done` stays 0, and `cru_idx`, `cru_dout` and `eq_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr_word | input | 16 | Opcode in high byte, signed displacement in low byte |
| base_reg | input | 16 | Bus-level CRU base address |
| cru_din | input | 1 | Sampled CRU input line |
| idle | output | 1 | Unit can accept an instruction |
| done | output | 1 | One-cycle completion pulse |
| eq_flag | output | 1 | Equal-status result of the last bit test |
| cru_idx | output | 12 | Bit index on the CRU address lines |
| cru_dout | output | 1 | CRU output data bit |
| cru_wstb | output | 1 | CRU output strobe |

## Verification
Address formation is exercised with zero, positive and negative displacements. These separate a correct doubling and sign extension from a missing shift or a zero extension. A base with an odd low bit and a base with high bits set show whether the dropped lines are really discarded, and a negative displacement from base zero exposes wrap handling. The 0x1F00/+1 against 0x1F02/0 pair confirms the base and displacement scales agree. Set, clear and test are each run with both input levels where relevant, to tell data polarity, strobe suppression on test and the sampling cycle apart.

// File: rtl/cru_bit_pkg.sv
`timescale 1ns/1ps
// Shared opcode constants and enumerations for the CRU single-bit executor.
// Assumes the opcode sits in the high byte of a 16-bit instruction word.
package cru_bit_pkg;
    localparam logic [7:0] OPC_SET = 8'h1D;
    localparam logic [7:0] OPC_CLR = 8'h1E;
    localparam logic [7:0] OPC_TST = 8'h1F;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_TST  = 2'd2,
        OP_NONE = 2'd3
    } cru_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2,
        ST_FIN  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/cru_op_decode.sv
`timescale 1ns/1ps
// Splits an instruction word into an operation class and a displacement.
// Assumes the opcode is in the upper byte and the displacement in the lower
// DISP_W bits; any unknown opcode maps to OP_NONE.
module cru_op_decode
    import cru_bit_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [WORD_W-1:0] instr_word,
    output cru_op_e           op,
    output logic [DISP_W-1:0] disp
);
    localparam int OPC_LSB = WORD_W - 8;

    logic [7:0] opc;
    assign opc  = instr_word[WORD_W-1:OPC_LSB];
    assign disp = instr_word[DISP_W-1:0];

    // Map the opcode byte onto an operation class.
    always_comb begin
        unique case (opc)
            OPC_SET: op = OP_SET;
            OPC_CLR: op = OP_CLR;
            OPC_TST: op = OP_TST;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/cru_addr_gen.sv
`timescale 1ns/1ps
// Forms the CRU bit index: base + 2*signed displacement, wrapped to ADDR_W
// bits, then bits IDX_W..1 taken. Assumes ADDR_W > DISP_W + 1 or equal.
module cru_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int IDX_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [IDX_W-1:0]  idx
);
    localparam int EXT_W = ADDR_W - DISP_W - 1;

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] sum;

    // Sign-extend and double the displacement to full bus width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign offs = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        end else begin : g_trunc
            assign offs = {disp[ADDR_W-2:0], 1'b0};
        end
    endgenerate

    // Modular add; the line below bit 1 and lines above IDX_W are dropped.
    always_comb begin
        sum = base + offs;
        idx = sum[IDX_W:1];
    end
endmodule

// File: rtl/cru_bus_seq.sv
`timescale 1ns/1ps
// Sequences one CRU bus transaction: address setup, strobe or sample, finish.
// Assumes the index and operation are valid while start_req is high; a
// request is taken only from ST_IDLE.
module cru_bus_seq
    import cru_bit_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  cru_op_e          op,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    output logic             idle,
    output logic             done,
    output logic             eq,
    output logic [IDX_W-1:0] addr,
    output logic             dout,
    output logic             wstb
);
    seq_st_e          st;
    cru_op_e          op_q;
    logic [IDX_W-1:0] addr_q;
    logic             dout_q, wstb_q, done_q, eq_q;

    // Advance the transaction and register every bus output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
            dout_q <= 1'b0;
            wstb_q <= 1'b0;
            done_q <= 1'b0;
            eq_q   <= 1'b0;
        end else begin
            wstb_q <= 1'b0;
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_req && op != OP_NONE) begin
                        addr_q <= idx;
                        op_q   <= op;
                        if (op == OP_SET) dout_q <= 1'b1;
                        else if (op == OP_CLR) dout_q <= 1'b0;
                        st <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (op_q != OP_TST) wstb_q <= 1'b1;
                    st <= ST_XFER;
                end
                ST_XFER: begin
                    if (op_q == OP_TST) eq_q <= din;
                    done_q <= 1'b1;
                    st     <= ST_FIN;
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign idle = (st == ST_IDLE);
    assign done = done_q;
    assign eq   = eq_q;
    assign addr = addr_q;
    assign dout = dout_q;
    assign wstb = wstb_q;

    // R5
    wstb_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wstb |=> !wstb);
    // R5
    wstb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wstb |-> ($stable(addr) && $stable(dout)));
    // R7
    tst_no_wstb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_TST && st != ST_IDLE) |-> !wstb);
    // R7
    eq_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_TST) |-> (eq == $past(din)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && idle));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER || st == ST_FIN) |-> ($stable(addr) && $stable(dout)));
    // R10
    illegal_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_req && op == OP_NONE) |=> (idle && $stable(addr) && $stable(eq)));
endmodule

// File: rtl/cru_bit_exec.sv
`timescale 1ns/1ps
// Top of the CRU single-bit executor: decodes set/clear/test, forms the bit
// index from the base register and runs one bus transaction per instruction.
// Assumes instr_word is held while instr_valid is high and idle is high.
module cru_bit_exec
    import cru_bit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [ADDR_W-1:0] instr_word,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic              cru_din,
    output logic              idle,
    output logic              done,
    output logic              eq_flag,
    output logic [IDX_W-1:0]  cru_idx,
    output logic              cru_dout,
    output logic              cru_wstb
);
    cru_op_e           dec_op;
    logic [DISP_W-1:0] dec_disp;
    logic [IDX_W-1:0]  gen_idx;
    logic              start_req;

    cru_op_decode #(.WORD_W(ADDR_W), .DISP_W(DISP_W)) u_dec (
        .instr_word (instr_word),
        .op         (dec_op),
        .disp       (dec_disp)
    );

    cru_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_agen (
        .base (base_reg),
        .disp (dec_disp),
        .idx  (gen_idx)
    );

    // Requests are only offered to the sequencer while it is idle.
    assign start_req = instr_valid && idle;

    cru_bus_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .op        (dec_op),
        .idx       (gen_idx),
        .din       (cru_din),
        .idle      (idle),
        .done      (done),
        .eq        (eq_flag),
        .addr      (cru_idx),
        .dout      (cru_dout),
        .wstb      (cru_wstb)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (idle && !done && !cru_wstb && !cru_dout && !eq_flag && cru_idx == '0));
    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && instr_valid && dec_op != OP_NONE) |=> (!idle && !done));
endmodule

// File: tb/tb_cru_bit_exec.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_cru_bit_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0;
    logic [15:0] base_reg = 16'h0;
    logic        cru_din = 1'b0;
    logic        idle, done, eq_flag, cru_dout, cru_wstb;
    logic [11:0] cru_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cru_bit_exec dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .base_reg(base_reg), .cru_din(cru_din),
        .idle(idle), .done(done), .eq_flag(eq_flag), .cru_idx(cru_idx),
        .cru_dout(cru_dout), .cru_wstb(cru_wstb)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Bus index from the requirement: bits 12..1 of base + 2*sext(disp), mod 2^16.
    function automatic logic [11:0] want_idx(input logic [15:0] b, input logic [7:0] d);
        logic [15:0] s;
        s = b + {{7{d[7]}}, d, 1'b0};
        return s[12:1];
    endfunction

    // Runs one set (0x1D) or clear (0x1E) and checks every busy cycle.
    task automatic run_write(input string req, input logic [7:0] opc,
                             input logic [15:0] b, input logic [7:0] d);
        logic [11:0] ei;
        logic        ed;
        ei = want_idx(b, d);
        ed = (opc == 8'h1D);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {opc, d}; base_reg = b;
        @(negedge clk);
        instr_valid = 1'b0;
        check(req, "idx setup", cru_idx, ei);
        check(req, "dout setup", cru_dout, ed);
        check(req, "wstb setup", cru_wstb, 0);
        check("R8", "idle c1", idle, 0);
        @(negedge clk);
        check(req, "wstb xfer", cru_wstb, 1);
        check(req, "idx xfer", cru_idx, ei);
        check(req, "dout xfer", cru_dout, ed);
        check("R8", "done c2", done, 0);
        @(negedge clk);
        check(req, "wstb fin", cru_wstb, 0);
        check("R8", "done c3", done, 1);
        check("R8", "idle c3", idle, 0);
        @(negedge clk);
        check("R8", "done after", done, 0);
        check("R8", "idle after", idle, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "idle", idle, 1);
        check("R1", "done", done, 0);
        check("R1", "wstb", cru_wstb, 0);
        check("R1", "dout", cru_dout, 0);
        check("R1", "eq", eq_flag, 0);
        check("R1", "idx", cru_idx, 0);
    endtask

    task automatic t_addr_forms();
        run_write("R2", 8'h1D, 16'h1F00, 8'h00);
        check("R2", "base only idx", cru_idx, 12'hF80);
        run_write("R2", 8'h1E, 16'h1F01, 8'h00);
        check("R2", "odd base bit0 dropped", cru_idx, 12'hF80);
        run_write("R2", 8'h1D, 16'hE000, 8'h7F);
        check("R2", "high lines dropped", cru_idx, 12'h07F);
    endtask

    task automatic t_equiv();
        logic [11:0] first;
        run_write("R3", 8'h1D, 16'h1F00, 8'h01);
        first = cru_idx;
        check("R3", "0x1F00+1", first, 12'hF81);
        run_write("R3", 8'h1D, 16'h1F02, 8'h00);
        check("R3", "0x1F02+0 equals", cru_idx, first);
    endtask

    task automatic t_negative();
        run_write("R4", 8'h1E, 16'h1F00, 8'hFF);
        check("R4", "minus one", cru_idx, 12'hF7F);
        run_write("R4", 8'h1D, 16'h0000, 8'h80);
        check("R4", "wrap below zero", cru_idx, 12'hF80);
        run_write("R4", 8'h1E, 16'h0000, 8'hFF);
        check("R4", "wrap minus one", cru_idx, 12'hFFF);
    endtask

    task automatic t_set_clear();
        run_write("R5", 8'h1D, 16'h1100, 8'h03);
        check("R5", "set leaves dout high", cru_dout, 1);
        run_write("R6", 8'h1E, 16'h1100, 8'h03);
        check("R6", "clear leaves dout low", cru_dout, 0);
    endtask

    task automatic run_test(input logic lvl, input logic dout_before);
        cru_din = lvl;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {8'h1F, 8'h05}; base_reg = 16'h1F00;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R7", "idx", cru_idx, 12'hF85);
        check("R7", "wstb c1", cru_wstb, 0);
        @(negedge clk);
        check("R7", "wstb c2", cru_wstb, 0);
        @(negedge clk);
        cru_din = ~lvl;
        check("R7", "eq", eq_flag, lvl);
        check("R7", "dout kept", cru_dout, dout_before);
        check("R8", "done", done, 1);
        @(negedge clk);
        @(negedge clk);
        check("R7", "eq held", eq_flag, lvl);
    endtask

    task automatic t_test();
        run_write("R6", 8'h1E, 16'h1F00, 8'h00);
        run_test(1'b1, 1'b0);
        run_write("R5", 8'h1D, 16'h1F00, 8'h00);
        run_test(1'b0, 1'b1);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        instr_valid = 1'b1; instr_word = 16'h1D10; base_reg = 16'h1000;
        @(negedge clk);
        instr_word = 16'h1E22; base_reg = 16'h1400;
        check("R9", "idx first", cru_idx, 12'h810);
        @(negedge clk);
        check("R9", "idx kept", cru_idx, 12'h810);
        check("R9", "dout kept", cru_dout, 1);
        check("R9", "wstb", cru_wstb, 1);
        @(negedge clk);
        instr_valid = 1'b0;
        check("R9", "done", done, 1);
        @(negedge clk);
        check("R9", "no second start", idle, 1);
        check("R9", "idx final", cru_idx, 12'h810);
        check("R9", "dout final", cru_dout, 1);
    endtask

    task automatic t_illegal();
        logic [11:0] i0;
        logic d0, e0;
        i0 = cru_idx; d0 = cru_dout; e0 = eq_flag;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = 16'h2005; base_reg = 16'h0300;
        @(negedge clk);
        instr_word = 16'h1C01;
        check("R10", "idle", idle, 1);
        check("R10", "done", done, 0);
        check("R10", "idx", cru_idx, i0);
        @(negedge clk);
        instr_valid = 1'b0;
        check("R10", "idle 2", idle, 1);
        check("R10", "idx 2", cru_idx, i0);
        check("R10", "dout", cru_dout, d0);
        check("R10", "eq", eq_flag, e0);
        check("R10", "wstb", cru_wstb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_addr_forms();
        t_equiv();
        t_negative();
        t_set_clear();
        t_test();
        t_busy_ignore();
        t_illegal();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule